// File: doc/BRIEF.md
# DRAM Bank and Row/Column Address Decoder

This block takes a physical byte address and splits it into the three coordinates that a DRAM sequencer needs. These are a bank number, a row address and a column address, for an array of four banks built from x16 devices. Each bank has its own 2-bit capacity code. The code sets how many row and column bits the bank's devices use. Banks sit at fixed 16 MB strides, so the bank number never depends on the configuration. Only the row and column masking and the in-range test do.

The block also flags whether the address lands in storage that really exists. The addressed bank must be marked present, and the offset inside the 16 MB window must fall below the bank's capacity. One address is accepted per cycle. The result appears one cycle later with a matching valid. The coordinate outputs keep their last value while no new address arrives.

Top module: `dram_addr_decoder`

## Requirements
- R1: `out_bank` equals bits [25:24] of the accepted address.
- R2: `out_col` equals the address shifted right by 2 and masked to the bank's column width; bits above that width are zero.
- R3: `out_row` equals the address shifted right by 13 and masked to the bank's row width; bits above that width are zero.
- R4: Bank b takes its capacity code from `cfg_sizes[2b+1:2b]`. The codes decode as follows: code 0 gives 1 MB with 9 row and 9 column bits, code 1 gives 4 MB with 10/10, code 2 gives 16 MB with 11/11, and code 3 gives 8 MB with 11 row and 10 column bits.
- R5: `out_hit` is 1 exactly when the result is valid, `present_mask[bank]` is 1, address bits [31:26] are zero and address bits [23:0] are below the bank's capacity.
- R6: `out_valid` is `in_valid` delayed by exactly one clock; back-to-back inputs give back-to-back results.
- R7: After a synchronous active-low reset, `out_valid`, `out_hit`, `out_bank`, `out_row` and `out_col` are all zero.
- R8: In a cycle with `in_valid` low, changes to `in_addr`, `cfg_sizes` or `present_mask` leave `out_bank`, `out_row` and `out_col` unchanged.
- R9: The configuration and present mask are applied in the same cycle an address is accepted; a change arriving together with an address is used for that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Address present this cycle |
| in_addr | input | 32 | Physical byte address |
| cfg_sizes | input | 8 | Capacity code per bank, 2 bits each |
| present_mask | input | 4 | One bit per bank, 1 = populated |
| out_valid | output | 1 | Decoded result valid |
| out_bank | output | 2 | Bank number |
| out_row | output | 11 | Row address, zero-extended |
| out_col | output | 11 | Column address, zero-extended |
| out_hit | output | 1 | Address maps to existing storage |

## Verification
Two things can happen in the same cycle: a geometry reconfiguration and an address decode. The bench provokes this by changing `cfg_sizes` and `present_mask` at the very edge where each new address is presented. Every sweep step does this, with a different code assigned to each bank, and the result one cycle later is compared against masks and limits computed from the new configuration alone. Separately, idle cycles that alter every input are checked to leave the held coordinates untouched.

// File: rtl/dram_dec_pkg.sv
// Shared types for the DRAM address decoder.
// Holds the capacity code encoding and the geometry lookup.
// The code order is not monotonic in capacity: code 2 is the largest bank.
package dram_dec_pkg;

    typedef enum logic [1:0] {
        SZ_1M  = 2'd0,
        SZ_4M  = 2'd1,
        SZ_16M = 2'd2,
        SZ_8M  = 2'd3
    } bank_size_e;

    typedef struct packed {
        logic [3:0] row_w;
        logic [3:0] col_w;
        logic [4:0] size_log2;
    } bank_geom_t;

    // Map a capacity code to its row width, column width and byte size (log2).
    function automatic bank_geom_t geom_of(input bank_size_e code);
        bank_geom_t g;
        case (code)
            SZ_1M:   g = '{row_w: 4'd9,  col_w: 4'd9,  size_log2: 5'd20};
            SZ_4M:   g = '{row_w: 4'd10, col_w: 4'd10, size_log2: 5'd22};
            SZ_8M:   g = '{row_w: 4'd11, col_w: 4'd10, size_log2: 5'd23};
            default: g = '{row_w: 4'd11, col_w: 4'd11, size_log2: 5'd24};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/dram_geom_decode.sv
// Turns one bank's capacity code into bit masks.
// Outputs a row mask, a column mask and an offset mask.
// The offset mask has every bit below the bank size set.
// Assumes the widths stay within MAX_ROW_W / MAX_COL_W / OFS_W.
module dram_geom_decode
    import dram_dec_pkg::*;
#(
    parameter int MAX_ROW_W = 11,
    parameter int MAX_COL_W = 11,
    parameter int OFS_W     = 24
) (
    input  logic [1:0]           code,
    output logic [MAX_ROW_W-1:0] row_mask,
    output logic [MAX_COL_W-1:0] col_mask,
    output logic [OFS_W-1:0]     size_mask
);

    bank_geom_t geom;

    // Expand the looked-up widths into thermometer masks.
    always_comb begin
        geom = geom_of(bank_size_e'(code));
        for (int i = 0; i < MAX_ROW_W; i++) row_mask[i]  = (i < int'(geom.row_w));
        for (int i = 0; i < MAX_COL_W; i++) col_mask[i]  = (i < int'(geom.col_w));
        for (int i = 0; i < OFS_W; i++)     size_mask[i] = (i < int'(geom.size_log2));
    end

endmodule

// File: rtl/dram_bank_select.sv
// Chooses the addressed bank's masks and present bit.
// Inputs are the per-bank decoded masks and the bank number.
// Assumes the bank number is always below NUM_BANKS.
module dram_bank_select #(
    parameter int NUM_BANKS = 4,
    parameter int MAX_ROW_W = 11,
    parameter int MAX_COL_W = 11,
    parameter int OFS_W     = 24,
    parameter int BSEL_W    = 2
) (
    input  logic [BSEL_W-1:0]                   bank,
    input  logic [NUM_BANKS-1:0][MAX_ROW_W-1:0] row_masks,
    input  logic [NUM_BANKS-1:0][MAX_COL_W-1:0] col_masks,
    input  logic [NUM_BANKS-1:0][OFS_W-1:0]     size_masks,
    input  logic [NUM_BANKS-1:0]                present,
    output logic [MAX_ROW_W-1:0]                sel_row_mask,
    output logic [MAX_COL_W-1:0]                sel_col_mask,
    output logic [OFS_W-1:0]                    sel_size_mask,
    output logic                                sel_present
);

    // Plain index multiplexer over the bank-wide vectors.
    always_comb begin
        sel_row_mask  = row_masks[bank];
        sel_col_mask  = col_masks[bank];
        sel_size_mask = size_masks[bank];
        sel_present   = present[bank];
    end

endmodule

// File: rtl/dram_addr_split.sv
// Slices a byte address into bank, row and column fields.
// Also computes the in-range test against the selected bank's masks.
// Assumes ADDR_W > BANK_SHIFT + BSEL_W, so some address bits lie above the array.
module dram_addr_split #(
    parameter int ADDR_W     = 32,
    parameter int BANK_SHIFT = 24,
    parameter int BSEL_W     = 2,
    parameter int ROW_SHIFT  = 13,
    parameter int COL_SHIFT  = 2,
    parameter int MAX_ROW_W  = 11,
    parameter int MAX_COL_W  = 11
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [MAX_ROW_W-1:0]  row_mask,
    input  logic [MAX_COL_W-1:0]  col_mask,
    input  logic [BANK_SHIFT-1:0] size_mask,
    input  logic                  present,
    output logic [BSEL_W-1:0]     bank,
    output logic [MAX_ROW_W-1:0]  row,
    output logic [MAX_COL_W-1:0]  col,
    output logic                  hit
);

    localparam int TOP_LO = BANK_SHIFT + BSEL_W;

    logic [ADDR_W-1:0]     row_sh;
    logic [ADDR_W-1:0]     col_sh;
    logic [BANK_SHIFT-1:0] offset;
    logic                  above_array;
    logic                  beyond_size;

    // Field extraction and range test.
    always_comb begin
        bank        = addr[BANK_SHIFT +: BSEL_W];
        row_sh      = addr >> ROW_SHIFT;
        col_sh      = addr >> COL_SHIFT;
        row         = row_sh[MAX_ROW_W-1:0] & row_mask;
        col         = col_sh[MAX_COL_W-1:0] & col_mask;
        offset      = addr[BANK_SHIFT-1:0];
        above_array = |addr[ADDR_W-1:TOP_LO];
        beyond_size = |(offset & ~size_mask);
        hit         = present & ~above_array & ~beyond_size;
    end

endmodule

// File: rtl/dram_addr_decoder.sv
// Top of the DRAM address decoder.
// It decodes every bank's capacity code in parallel.
// It picks the addressed bank's geometry and registers the split address.
// Latency is one cycle. Coordinates hold while idle; hit is qualified by valid.
module dram_addr_decoder
    import dram_dec_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_BANKS  = 4,
    parameter int BANK_SHIFT = 24,
    parameter int ROW_SHIFT  = 13,
    parameter int COL_SHIFT  = 2,
    parameter int MAX_ROW_W  = 11,
    parameter int MAX_COL_W  = 11,
    localparam int BSEL_W    = $clog2(NUM_BANKS),
    localparam int CFG_W     = 2 * NUM_BANKS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [ADDR_W-1:0]     in_addr,
    input  logic [CFG_W-1:0]      cfg_sizes,
    input  logic [NUM_BANKS-1:0]  present_mask,
    output logic                  out_valid,
    output logic [BSEL_W-1:0]     out_bank,
    output logic [MAX_ROW_W-1:0]  out_row,
    output logic [MAX_COL_W-1:0]  out_col,
    output logic                  out_hit
);

    logic [NUM_BANKS-1:0][MAX_ROW_W-1:0]  row_masks;
    logic [NUM_BANKS-1:0][MAX_COL_W-1:0]  col_masks;
    logic [NUM_BANKS-1:0][BANK_SHIFT-1:0] size_masks;

    logic [MAX_ROW_W-1:0]  sel_row_mask;
    logic [MAX_COL_W-1:0]  sel_col_mask;
    logic [BANK_SHIFT-1:0] sel_size_mask;
    logic                  sel_present;

    logic [BSEL_W-1:0]     bank_c;
    logic [MAX_ROW_W-1:0]  row_c;
    logic [MAX_COL_W-1:0]  col_c;
    logic                  hit_c;

    // One geometry decoder per bank, all evaluated every cycle.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dram_geom_decode #(
            .MAX_ROW_W (MAX_ROW_W),
            .MAX_COL_W (MAX_COL_W),
            .OFS_W     (BANK_SHIFT)
        ) i_geom (
            .code      (cfg_sizes[2*b +: 2]),
            .row_mask  (row_masks[b]),
            .col_mask  (col_masks[b]),
            .size_mask (size_masks[b])
        );
    end

    dram_bank_select #(
        .NUM_BANKS (NUM_BANKS),
        .MAX_ROW_W (MAX_ROW_W),
        .MAX_COL_W (MAX_COL_W),
        .OFS_W     (BANK_SHIFT),
        .BSEL_W    (BSEL_W)
    ) i_sel (
        .bank          (in_addr[BANK_SHIFT +: BSEL_W]),
        .row_masks     (row_masks),
        .col_masks     (col_masks),
        .size_masks    (size_masks),
        .present       (present_mask),
        .sel_row_mask  (sel_row_mask),
        .sel_col_mask  (sel_col_mask),
        .sel_size_mask (sel_size_mask),
        .sel_present   (sel_present)
    );

    dram_addr_split #(
        .ADDR_W     (ADDR_W),
        .BANK_SHIFT (BANK_SHIFT),
        .BSEL_W     (BSEL_W),
        .ROW_SHIFT  (ROW_SHIFT),
        .COL_SHIFT  (COL_SHIFT),
        .MAX_ROW_W  (MAX_ROW_W),
        .MAX_COL_W  (MAX_COL_W)
    ) i_split (
        .addr      (in_addr),
        .row_mask  (sel_row_mask),
        .col_mask  (sel_col_mask),
        .size_mask (sel_size_mask),
        .present   (sel_present),
        .bank      (bank_c),
        .row       (row_c),
        .col       (col_c),
        .hit       (hit_c)
    );

    // Output stage: valid and hit every cycle, coordinates only on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_bank  <= '0;
            out_row   <= '0;
            out_col   <= '0;
        end else begin
            out_valid <= in_valid;
            out_hit   <= in_valid & hit_c;
            if (in_valid) begin
                out_bank <= bank_c;
                out_row  <= row_c;
                out_col  <= col_c;
            end
        end
    end

    // Result valid tracks the input valid one cycle later.
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid && rst_n));

    // Bank number comes straight from the fixed-stride address field.
    p_bank_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_bank == $past(in_addr[BANK_SHIFT +: BSEL_W]));

    // Column and row never carry bits beyond the selected bank's geometry.
    p_col_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_col & ~$past(sel_col_mask)) == '0);
    p_row_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_row & ~$past(sel_row_mask)) == '0);

    // A hit needs a valid result and a populated bank.
    p_hit_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> out_valid);
    p_hit_present_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> $past(present_mask[in_addr[BANK_SHIFT +: BSEL_W]]));

    // Idle cycles leave the coordinates alone.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(out_bank) && $stable(out_row) && $stable(out_col)));

endmodule

// File: tb/test_dram_addr_decoder.sv
module test_dram_addr_decoder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_addr;
    logic [7:0]  cfg_sizes;
    logic [3:0]  present_mask;
    logic        out_valid;
    logic [1:0]  out_bank;
    logic [10:0] out_row;
    logic [10:0] out_col;
    logic        out_hit;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    dram_addr_decoder i_dram_addr_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_addr      (in_addr),
        .cfg_sizes    (cfg_sizes),
        .present_mask (present_mask),
        .out_valid    (out_valid),
        .out_bank     (out_bank),
        .out_row      (out_row),
        .out_col      (out_col),
        .out_hit      (out_hit)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Geometry from the R4 encoding.
    function automatic int rw_of(input int c);
        return (c == 0) ? 9 : (c == 1) ? 10 : 11;
    endfunction
    function automatic int cw_of(input int c);
        return (c == 0) ? 9 : (c == 2) ? 11 : 10;
    endfunction
    function automatic int szl_of(input int c);
        return (c == 0) ? 20 : (c == 1) ? 22 : (c == 3) ? 23 : 24;
    endfunction

    // Present one address together with a configuration, check one cycle later.
    task automatic decode(input logic [31:0] a, input logic [7:0] cfg, input logic [3:0] pm);
        int b, c;
        logic [31:0] er, ec;
        logic        eh;
        in_valid     = 1'b1;
        in_addr      = a;
        cfg_sizes    = cfg;
        present_mask = pm;
        b  = int'(a[25:24]);
        c  = int'((cfg >> (2 * b)) & 8'h3);
        er = (a >> 13) & ((32'd1 << rw_of(c)) - 1);
        ec = (a >> 2)  & ((32'd1 << cw_of(c)) - 1);
        eh = (a[31:26] == 6'd0) && pm[b] && ({8'd0, a[23:0]} < (32'd1 << szl_of(c)));
        @(negedge clk);
        check("R6 valid", int'(out_valid), 1);
        check("R1 bank", int'(out_bank), b);
        check("R3/R4/R9 row", int'(out_row), int'(er));
        check("R2/R4/R9 col", int'(out_col), int'(ec));
        check("R5 hit", int'(out_hit), int'(eh));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [10:0] h_row, h_col;
        logic [1:0]  h_bank;
        rst_n = 1'b0; in_valid = 1'b0; in_addr = 32'h0123_4567;
        cfg_sizes = 8'hAA; present_mask = 4'hF;
        repeat (4) @(negedge clk);
        // R7: state under reset
        check("R7 valid", int'(out_valid), 0);
        check("R7 hit", int'(out_hit), 0);
        check("R7 bank", int'(out_bank), 0);
        check("R7 row", int'(out_row), 0);
        check("R7 col", int'(out_col), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 idle valid", int'(out_valid), 0);

        // Sweep: per-bank codes rotate, config changes at each accepted address (R9).
        for (int rot = 0; rot < 4; rot++) begin
            for (int pmi = 0; pmi < 3; pmi++) begin
                logic [3:0] pm;
                logic [7:0] cfg;
                pm  = (pmi == 0) ? 4'hF : (pmi == 1) ? 4'h5 : 4'hA;
                cfg = '0;
                for (int b = 0; b < 4; b++) cfg[2*b +: 2] = 2'((rot + b) % 4);
                for (int b = 0; b < 4; b++) begin
                    int c;
                    logic [31:0] sz, base;
                    c    = (rot + b) % 4;
                    sz   = 32'd1 << szl_of(c);
                    base = 32'(b) << 24;
                    decode(base, cfg, pm);
                    decode(base + sz - 32'd4, cfg, pm);
                    decode(base + (sz & 32'h00FF_FFFF), cfg, pm);
                    decode(base + 32'h00FF_FFFC, cfg, pm);
                    decode(base + 32'h000A_5A5C, cfg, pm);
                    decode(base + 32'h0055_3FF8, cfg, pm);
                    decode(base | 32'h0400_0000, cfg, pm);
                    decode(base | 32'h8000_0004, cfg, pm);
                end
            end
        end

        // R9: same address, configuration swapped on the accepting edge.
        decode(32'h0080_2004, 8'h00, 4'hF);
        decode(32'h0080_2004, 8'h02, 4'hF);
        decode(32'h0080_2004, 8'h03, 4'hE);

        // R8: idle cycles with every input changing leave coordinates held.
        decode(32'h02F3_7FFC, 8'hAA, 4'hF);
        h_row = out_row; h_col = out_col; h_bank = out_bank;
        for (int k = 0; k < 4; k++) begin
            in_valid     = 1'b0;
            in_addr      = 32'h5A5A_5A5A ^ (32'(k) << 24);
            cfg_sizes    = 8'(k * 37);
            present_mask = 4'(k);
            @(negedge clk);
            check("R6 idle valid", int'(out_valid), 0);
            check("R5 idle hit", int'(out_hit), 0);
            check("R8 hold row", int'(out_row), int'(h_row));
            check("R8 hold col", int'(out_col), int'(h_col));
            check("R8 hold bank", int'(out_bank), int'(h_bank));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule